// File: doc/BRIEF.md
# Write Buffer with Read Forwarding

This block is a short queue placed between a write-through data cache and a slower memory port. The processor hands it a store as a word address, a data word and a byte-enable mask. The store is finished as soon as the queue takes it. In the background the queue sends its entries to memory, oldest first, over a valid/ready port that it shares with read misses.

A read miss that goes to memory is first compared against every entry held in the queue, all at once. If no entry holds the same word, the read goes straight to the memory port. A read and a drain can both want the port in the same cycle. When that happens the read wins, but only when no queued write matches it. When the newest matching entry writes the whole word, the read is answered from the queue in the same cycle. When that entry writes only some bytes, the read waits until the entry has drained. A store that finds the queue full is stalled, unless an entry leaves in that same cycle.

Top module: `wbuf_fwd_top`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released, the queue is empty: `st_stall`, `rd_ready`, `rd_fwd` and `mem_valid` are low whenever `st_valid` and `rd_valid` are low.
- R2: An accepted store (`st_valid` high and `st_stall` low) is written to memory later with `mem_we` high, carrying its own address, data and byte mask. Entries leave in the order they arrived, at most one per cycle, and an entry leaves only in a cycle where `mem_valid`, `mem_we` and `mem_ready` are all high.
- R3: `st_stall` is high exactly when `st_valid` is high, all DEPTH slots are taken, and no entry drains in that cycle. A full queue that drains and takes a store in the same cycle stays full.
- R4: When `rd_valid` is high and no queued entry holds `rd_addr`, the read is placed on the memory port in the same cycle (`mem_valid` high, `mem_we` low, `mem_addr` equal to `rd_addr`). In that case `rd_ready` equals `mem_ready` and `rd_fwd` is low.
- R5: A read that goes to memory takes the port ahead of a waiting drain, so no entry leaves in that cycle.
- R6: When the newest queued entry at `rd_addr` has all byte-mask bits set, `rd_ready` and `rd_fwd` are high and `rd_data` equals that entry's data in the same cycle. No memory read is issued, and the drain may proceed.
- R7: When several queued entries hold `rd_addr`, the one accepted most recently supplies `rd_data`.
- R8: When the newest queued entry at `rd_addr` has any byte-mask bit clear, `rd_ready` stays low and no memory read is issued until that entry has drained. Draining carries on while the read waits.
- R9: A store becomes visible to the read search one cycle after it is accepted. A read in the same cycle as the store does not see it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_valid | input | 1 | Processor offers a store |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Byte mask of the store, one bit per byte |
| st_stall | output | 1 | Store not taken this cycle; hold it |
| rd_valid | input | 1 | Read miss wants memory |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_ready | output | 1 | Read completed this cycle (forwarded or accepted by memory) |
| rd_fwd | output | 1 | Read answered from the queue |
| rd_data | output | DATA_W | Forwarded data, zero when `rd_fwd` is low |
| mem_valid | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = drain write, 0 = read |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Drain data, zero for reads |
| mem_be | output | DATA_W/8 | Drain byte mask, zero for reads |
| mem_ready | input | 1 | Memory takes the request this cycle |

## Verification
Every output is a combinational function of the registered queue and the inputs of the current cycle. So a read result, a stall decision and a memory request are all due in the same cycle as the stimulus that causes them. A store changes the outputs only from the cycle after it is accepted, which is when its entry can be seen by the search and the drain. The bench drives inputs on the falling edge and compares every output 1 ns later, still before the next rising edge. It then advances its own queue model with the same inputs that the design registers at that edge, so the expected values and the design's outputs always refer to the same cycle.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
// Package: shared types of the forwarding write buffer.
// Assumes nothing beyond standard SystemVerilog.
package wbuf_pkg;
    // Owner of the shared memory port in a cycle
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_READ  = 2'd1,
        PORT_DRAIN = 2'd2
    } port_sel_e;
endpackage

// File: rtl/wbuf_store.sv
`timescale 1ns/1ps
// Module: wbuf_store
// Circular store queue with a head pointer and an occupancy count.
// Shows every slot, with its valid flag, to the search logic, and shows the head entry to the drain.
// Assumes DEPTH is a power of two, at least 2, and that pop is only raised when the queue is not empty.
module wbuf_store #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [ADDR_W-1:0]             push_addr,
    input  logic [DATA_W-1:0]             push_data,
    input  logic [BE_W-1:0]               push_be,
    input  logic                          pop,
    output logic [PTR_W-1:0]              head,
    output logic                          full,
    output logic                          empty,
    output logic [DEPTH-1:0]              slot_vld,
    output logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    output logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
    output logic [DEPTH-1:0][BE_W-1:0]    slot_be,
    output logic [ADDR_W-1:0]             head_addr,
    output logic [DATA_W-1:0]             head_data,
    output logic [BE_W-1:0]               head_be
);
    localparam logic [PTR_W:0] CNT_MAX = (PTR_W+1)'(DEPTH);

    logic [PTR_W:0]   count;
    logic [PTR_W-1:0] tail;

    assign tail  = head + count[PTR_W-1:0];
    assign full  = (count == CNT_MAX);
    assign empty = (count == '0);

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            count <= '0;
        end else begin
            if (pop) head <= head + 1'b1;
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Slot payload write at the tail
    always_ff @(posedge clk) begin
        if (push) begin
            slot_addr[tail] <= push_addr;
            slot_data[tail] <= push_data;
            slot_be[tail]   <= push_be;
        end
    end

    // Per-slot valid flag from the slot's age relative to the head
    for (genvar i = 0; i < DEPTH; i++) begin : g_vld
        logic [PTR_W-1:0] age;
        assign age         = PTR_W'(i) - head;
        assign slot_vld[i] = ({1'b0, age} < count);
    end

    assign head_addr = slot_addr[head];
    assign head_data = slot_data[head];
    assign head_be   = slot_be[head];

    // A push into a full queue is legal only together with a pop
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // A drain never takes from an empty queue
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // Count stays within the number of slots
    p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX);

    // Exactly count slots are marked valid
    p_vld_matches_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(slot_vld) == int'(count));
endmodule

// File: rtl/wbuf_search.sv
`timescale 1ns/1ps
// Module: wbuf_search
// Compares a read address with every valid slot at once and reports the match
// that is newest in queue order, together with that entry's data and whether it covers the whole word.
// Assumes the slots at ages 0 .. count-1 counted from the head are the valid ones.
module wbuf_search #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int BE_W   = DATA_W / 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic [PTR_W-1:0]              head,
    input  logic [DEPTH-1:0]              slot_vld,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  slot_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0]  slot_data,
    input  logic [DEPTH-1:0][BE_W-1:0]    slot_be,
    input  logic [ADDR_W-1:0]             look_addr,
    output logic                          hit,
    output logic                          hit_full,
    output logic [DATA_W-1:0]             hit_data
);
    // Walk from oldest to newest so that the last match seen wins
    always_comb begin
        logic [PTR_W-1:0] idx;
        hit      = 1'b0;
        hit_full = 1'b0;
        hit_data = '0;
        idx      = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PTR_W'(k);
            if (slot_vld[idx] && (slot_addr[idx] == look_addr)) begin
                hit      = 1'b1;
                hit_full = &slot_be[idx];
                hit_data = slot_data[idx];
            end
        end
    end
endmodule

// File: rtl/wbuf_arb.sv
`timescale 1ns/1ps
// Module: wbuf_arb
// Decides who owns the memory port each cycle and derives the handshakes on the processor side.
// Order of precedence: a read with no matching entry, then the drain.
// A read that matches a queued entry never reaches memory.
// Assumes hit and hit_full come from the search of the current read address.
module wbuf_arb
    import wbuf_pkg::*;
(
    input  logic      rd_valid,
    input  logic      hit,
    input  logic      hit_full,
    input  logic      empty,
    input  logic      full,
    input  logic      st_valid,
    input  logic      mem_ready,
    output port_sel_e port_sel,
    output logic      drain,
    output logic      rd_ready,
    output logic      rd_fwd,
    output logic      st_stall
);
    logic rd_to_mem;

    // Port ownership: a read miss first, otherwise the head entry
    always_comb begin
        rd_to_mem = rd_valid && !hit;
        if (rd_to_mem)   port_sel = PORT_READ;
        else if (!empty) port_sel = PORT_DRAIN;
        else             port_sel = PORT_IDLE;
    end

    // Handshake outcome of this cycle
    always_comb begin
        drain    = (port_sel == PORT_DRAIN) && mem_ready;
        rd_fwd   = rd_valid && hit && hit_full;
        rd_ready = rd_fwd || (rd_to_mem && mem_ready);
        st_stall = st_valid && full && !drain;
    end
endmodule

// File: rtl/wbuf_fwd_top.sv
`timescale 1ns/1ps
// Module: wbuf_fwd_top
// Write buffer placed between a write-through cache and memory. Stores are queued and
// drained oldest first. Read misses search the queue: a whole-word match is forwarded,
// a partial match waits, and no match goes to memory ahead of the drain.
// Assumes word addresses, that DEPTH is a power of two at least 2, and that a stalled
// store or read is held stable by the requester.
module wbuf_fwd_top
    import wbuf_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [DATA_W/8-1:0]   st_be,
    output logic                  st_stall,
    input  logic                  rd_valid,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic                  rd_ready,
    output logic                  rd_fwd,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  mem_valid,
    output logic                  mem_we,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_wdata,
    output logic [DATA_W/8-1:0]   mem_be,
    input  logic                  mem_ready
);
    localparam int BE_W  = DATA_W / 8;
    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0]             head;
    logic                         full, empty, drain, push;
    logic [DEPTH-1:0]             slot_vld;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;
    logic [DEPTH-1:0][BE_W-1:0]   slot_be;
    logic [ADDR_W-1:0]            head_addr;
    logic [DATA_W-1:0]            head_data;
    logic [BE_W-1:0]              head_be;
    logic                         hit, hit_full;
    logic [DATA_W-1:0]            hit_data;
    port_sel_e                    port_sel;

    assign push = st_valid && !st_stall;

    wbuf_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .PTR_W(PTR_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
        .pop(drain), .head(head), .full(full), .empty(empty),
        .slot_vld(slot_vld), .slot_addr(slot_addr), .slot_data(slot_data), .slot_be(slot_be),
        .head_addr(head_addr), .head_data(head_data), .head_be(head_be)
    );

    wbuf_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .PTR_W(PTR_W)) u_search (
        .head(head), .slot_vld(slot_vld), .slot_addr(slot_addr), .slot_data(slot_data),
        .slot_be(slot_be), .look_addr(rd_addr),
        .hit(hit), .hit_full(hit_full), .hit_data(hit_data)
    );

    wbuf_arb u_arb (
        .rd_valid(rd_valid), .hit(hit), .hit_full(hit_full), .empty(empty), .full(full),
        .st_valid(st_valid), .mem_ready(mem_ready),
        .port_sel(port_sel), .drain(drain), .rd_ready(rd_ready), .rd_fwd(rd_fwd),
        .st_stall(st_stall)
    );

    // Memory port steering by the arbiter's choice
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        case (port_sel)
            PORT_READ: begin
                mem_valid = 1'b1;
                mem_addr  = rd_addr;
            end
            PORT_DRAIN: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = head_addr;
                mem_wdata = head_data;
                mem_be    = head_be;
            end
            default: ;
        endcase
    end

    assign rd_data = rd_fwd ? hit_data : '0;

    // A matching read never appears on the memory port
    p_no_overtake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && hit) |-> !(mem_valid && !mem_we));

    // A read with no match owns the port, so nothing drains
    p_read_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !hit) |-> (mem_valid && !mem_we && !drain));

    // A stall is raised only when all slots are taken
    p_stall_only_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> full);

    // A forwarded read always completes
    p_fwd_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fwd |-> (rd_ready && hit));

    // An accepted store leaves the queue non-empty in the next cycle
    p_store_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !empty);
endmodule

// File: tb/wbuf_fwd_top_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural queue model, compared with the design's outputs in every cycle.
module wbuf_fwd_top_tb_top;
    localparam int DEPTH = 4;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int BW    = DW / 8;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [BW-1:0] b;
    } ent_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
    logic [AW-1:0] st_addr = '0, rd_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [BW-1:0] st_be = '0;
    logic          st_stall, rd_ready, rd_fwd, mem_valid, mem_we;
    logic [DW-1:0] rd_data, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_be;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    ent_t q[$];

    always #2.5 clk = ~clk;

    wbuf_fwd_top #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_stall(st_stall),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_fwd(rd_fwd),
        .rd_data(rd_data),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_be(mem_be), .mem_ready(mem_ready)
    );

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive on the falling edge, compare 1 ns later, then advance the model
    task automatic step(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                        input logic [BW-1:0] sb, input bit rv, input logic [AW-1:0] ra,
                        input bit mr, input bit in_reset);
        bit found, fullw, multi, to_mem, nonempty, drain, stall, e_rdy, e_fwd;
        logic [DW-1:0] fdata;
        string rtag;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd; st_be = sb;
        rd_valid = rv; rd_addr = ra; mem_ready = mr;
        #1;
        if (in_reset) q.delete();
        found = 0; fullw = 0; multi = 0; fdata = '0;
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].a == ra) begin
                if (found) multi = 1;
                else begin
                    found = 1; fullw = (q[i].b == '1); fdata = q[i].d;
                end
            end
        end
        nonempty = (q.size() > 0);
        to_mem   = rv && !found;
        drain    = !to_mem && nonempty && mr;
        stall    = sv && (q.size() == DEPTH) && !drain;
        e_fwd    = rv && found && fullw;
        e_rdy    = e_fwd || (to_mem && mr);
        if (in_reset)      rtag = "R1";
        else if (!rv)      rtag = "R4";
        else if (found)    rtag = !fullw ? "R8" : (multi ? "R7" : "R6");
        else if (sv && sa == ra) rtag = "R9";
        else               rtag = "R4";
        chk(in_reset ? "R1" : "R3", "st_stall", 64'(st_stall), 64'(stall));
        chk(rtag, "rd_ready", 64'(rd_ready), 64'(e_rdy));
        chk(rtag, "rd_fwd", 64'(rd_fwd), 64'(e_fwd));
        chk(rtag, "rd_data", 64'(rd_data), e_fwd ? 64'(fdata) : 64'd0);
        chk(in_reset ? "R1" : (to_mem ? "R5" : "R2"), "mem_valid", 64'(mem_valid), 64'(to_mem || nonempty));
        if (to_mem) begin
            chk("R4", "mem_we", 64'(mem_we), 64'd0);
            chk("R4", "mem_addr", 64'(mem_addr), 64'(ra));
        end else if (nonempty) begin
            chk("R2", "mem_we", 64'(mem_we), 64'd1);
            chk("R2", "mem_addr", 64'(mem_addr), 64'(q[0].a));
            chk("R2", "mem_wdata", 64'(mem_wdata), 64'(q[0].d));
            chk("R2", "mem_be", 64'(mem_be), 64'(q[0].b));
        end
        if (!in_reset) begin
            if (drain) void'(q.pop_front());
            if (sv && !stall) q.push_back('{a: sa, d: sd, b: sb});
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        // R1: reset state, and the first cycle after release
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 1, 1);
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 1, 1);
        // R2/R3: fill the queue while memory is not ready
        step(1, 16'd1, 32'h11, 4'hF, 0, 0, 0, 0);
        step(1, 16'd2, 32'h22, 4'h3, 0, 0, 0, 0);
        step(1, 16'd1, 32'h33, 4'hF, 0, 0, 0, 0);
        step(1, 16'd3, 32'h44, 4'hF, 0, 0, 0, 0);
        step(1, 16'd4, 32'h55, 4'hF, 0, 0, 0, 0);   // R3 stall on full
        step(0, 0, 0, 0, 1, 16'd1, 0, 0);            // R7 newest of two matches
        step(0, 0, 0, 0, 1, 16'd3, 0, 0);            // R6 single whole-word match
        step(0, 0, 0, 0, 1, 16'd2, 0, 0);            // R8 partial match waits
        step(0, 0, 0, 0, 1, 16'd9, 0, 0);            // R4 miss, memory busy
        step(1, 16'd4, 32'h55, 4'hF, 1, 16'd9, 1, 0); // R5 read wins, store stays stalled
        step(1, 16'd5, 32'h66, 4'hF, 0, 0, 1, 0);    // R3 drain and store together
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 16'd2, 1, 0); // R8 resolves after drain
        step(1, 16'd6, 32'h77, 4'hF, 1, 16'd6, 1, 0); // R9 same-cycle store unseen
        step(0, 0, 0, 0, 1, 16'd6, 0, 0);            // R9 visible next cycle
        // Mixed traffic
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] b;
            b = ($urandom % 3 == 0) ? 4'($urandom) : 4'hF;
            step(bit'($urandom % 2), 16'($urandom % 6), $urandom, b,
                 bit'($urandom % 3 == 0), 16'($urandom % 7), bit'($urandom % 4 != 0), 0);
        end
        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end
endmodule